// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for 64 or 96 pins, grouped in banks of 32. Software reaches it through a simple 32-bit register port. For each pin it provides five controls. The first is a readable, synchronised pin level. The second is a direction bit that enables the pad driver. The third is a pair of write-one strobes that raise or lower the output latch. The fourth is a pair of independent rising-edge and falling-edge capture enables. The fifth is a sticky capture flag. A single interrupt line stays high while any capture flag in any bank is set.

Registers are grouped by type: every bank of one register type sits in a contiguous run of words, then the next type follows. Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its previous sample.

The bus side is a small state machine with two named states. `BUS_IDLE` means no read data is being presented. `BUS_RESP` means the read data for the request accepted on the previous edge is on `bus_rdata`, and `bus_rvalid` is high. There are two transitions. A read request (`bus_en` high, `bus_we` low) moves the machine to, or keeps it in, `BUS_RESP`. Any cycle without a read request returns it to `BUS_IDLE`. Writes take effect at the edge that samples them and produce no response.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: With NB = PINS/32 banks, the byte address of bank b of register type t is t*NB*4 + b*4. Pin p lives in bank p/32 at bit p%32. The type codes are: 0 level (read-only), 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 capture status. The direction, rising-enable and falling-enable registers read back the last value written.
- R2: A direction bit of 1 drives `pin_oe` high for that pin (output); 0 makes the pin an input.
- R3: A write to the set register raises the output latch (`pin_out`) of every pin whose data bit is 1, at the edge that samples the write. Zero bits leave the latch unchanged.
- R4: A write to the clear register lowers the output latch of every pin whose data bit is 1. Zero bits leave the latch unchanged.
- R5: The level register returns the pin input after a two-flop synchroniser. Read data and `bus_rvalid` appear one cycle after the read request is sampled. A pin change driven just before edge k is first returned by a read sampled at edge k+2.
- R6: A 0-to-1 transition of the synchronised level sets the pin's capture bit when its rising enable is 1. A 1-to-0 transition sets the bit when its falling enable is 1. No transition sets it when the matching enable is 0. The bit is set two edges after the edge that first samples the pin change.
- R7: A capture bit stays set until a 1 is written to it. Writing 0 leaves it unchanged.
- R8: When a new enabled edge and a write of 1 hit the same capture bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly while at least one capture bit in any bank is set.
- R10: Reads of the set and clear registers return 0. Addresses with nonzero bits [1:0], and addresses past the last register type, read 0 and ignore writes.
- R11: Reset clears all direction bits, output latches, both edge enables and all capture bits, so `pin_oe`, `pin_out` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | PINS | Asynchronous pin inputs |
| pin_out | output | PINS | Output latches |
| pin_oe | output | PINS | Output enables (direction) |
| irq | output | 1 | Any capture bit set |

## Verification
The timing of each result is fixed.
- A write to the direction, set or clear register shows on `pin_oe` or `pin_out` right after the edge that samples it.
- Read data arrives one cycle after the request.
- A pin change reaches the level register two edges after it is driven, and reaches the capture bit and `irq` three edges after it is driven.

Reads are pushed into a scoreboard queue with their expected word and are popped by a monitor when `bus_rvalid` rises. Pin-level checks are made at the falling edge that follows the counted rising edges. The checks also confirm the cycle just before a result is due: `irq` is still low, and a read issued in the same cycle as the pin change returns the old level. The case where an edge and a clear collide is staged by placing the clear write exactly on the edge where the captured edge lands.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_TYPES = 7;

    typedef enum logic [2:0] {
        RT_LEVEL = 3'd0,
        RT_DIR   = 3'd1,
        RT_SET   = 3'd2,
        RT_CLR   = 3'd3,
        RT_RISE  = 3'd4,
        RT_FALL  = 3'd5,
        RT_STAT  = 3'd6,
        RT_NONE  = 3'd7
    } reg_type_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] level,
    output logic [W-1:0] rise_p,
    output logic [W-1:0] fall_p
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level  = sync_q;
    assign rise_p = sync_q & ~prev_q;
    assign fall_p = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_type_e         wr_type,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] rise_p,
    input  logic [BANK_W-1:0] fall_p,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] rise_en_q,
    output logic [BANK_W-1:0] fall_en_q,
    output logic [BANK_W-1:0] stat_q
);
    logic [BANK_W-1:0] set_mask;
    logic [BANK_W-1:0] clr_mask;
    logic [BANK_W-1:0] ack_mask;
    logic [BANK_W-1:0] hit;

    assign set_mask = (wr_en && wr_type == RT_SET)  ? wdata : '0;
    assign clr_mask = (wr_en && wr_type == RT_CLR)  ? wdata : '0;
    assign ack_mask = (wr_en && wr_type == RT_STAT) ? wdata : '0;
    assign hit      = (rise_p & rise_en_q) | (fall_p & fall_en_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            unique case (wr_type)
                RT_DIR:  dir_q     <= wdata;
                RT_RISE: rise_en_q <= wdata;
                RT_FALL: fall_en_q <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            stat_q <= '0;
        end else begin
            out_q  <= (out_q | set_mask) & ~clr_mask;
            // a fresh edge outranks an acknowledge in the same cycle
            stat_q <= (stat_q & ~ack_mask) | hit;
        end
    end

    AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((out_q & $past(set_mask)) == $past(set_mask))); // R3
    AST_LATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((out_q & $past(clr_mask)) == '0)); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(out_q)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~ack_mask)) == $past(stat_q & ~ack_mask))); // R7
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(hit)) == $past(hit))); // R8
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
#(
    parameter int PINS   = 64,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_en,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [PINS-1:0]            lvl,
    input  logic [PINS-1:0]            dir,
    input  logic [PINS-1:0]            rise_en,
    input  logic [PINS-1:0]            fall_en,
    input  logic [PINS-1:0]            stat,
    output logic [PINS/BANK_W-1:0]     wr_bank,
    output reg_type_e                  wr_type,
    output logic [BANK_W-1:0]          bus_rdata,
    output logic                       bus_rvalid
);
    localparam int NB     = PINS / BANK_W;
    localparam int WORD_W = ADDR_W - 2;

    bus_state_e        state_q, state_d;
    logic [WORD_W-1:0] word;
    int                t_idx;
    int                b_idx;
    logic              in_range;
    logic              rd_req;
    logic [BANK_W-1:0] rd_sel;
    logic [BANK_W-1:0] rdata_q;

    assign word     = bus_addr[ADDR_W-1:2];
    assign t_idx    = int'(word) / NB;
    assign b_idx    = int'(word) % NB;
    assign in_range = (t_idx < NUM_TYPES) && (bus_addr[1:0] == 2'b00);
    assign wr_type  = in_range ? reg_type_e'(3'(t_idx)) : RT_NONE;
    assign rd_req   = bus_en && !bus_we;

    for (genvar b = 0; b < NB; b++) begin : g_wsel
        assign wr_bank[b] = bus_en && bus_we && in_range && (b_idx == b);
    end

    always_comb begin
        rd_sel = '0;
        unique case (wr_type)
            RT_LEVEL: rd_sel = lvl[b_idx*BANK_W +: BANK_W];
            RT_DIR:   rd_sel = dir[b_idx*BANK_W +: BANK_W];
            RT_RISE:  rd_sel = rise_en[b_idx*BANK_W +: BANK_W];
            RT_FALL:  rd_sel = fall_en[b_idx*BANK_W +: BANK_W];
            RT_STAT:  rd_sel = stat[b_idx*BANK_W +: BANK_W];
            default:  rd_sel = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_sel;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid); // R5
    AST_RVALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid); // R5
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_range) |=> (bus_rdata == '0)); // R10
    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_bank)); // R1
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_pkg::*;
#(
    parameter int PINS   = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int NB = PINS / BANK_W;

    logic [PINS-1:0] lvl, rise_p, fall_p;
    logic [PINS-1:0] dir, outl, rise_en, fall_en, stat;
    logic [NB-1:0]   wr_bank;
    reg_type_e       wr_type;

    gpio_sync_edge #(.W(PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .level     (lvl),
        .rise_p    (rise_p),
        .fall_p    (fall_p)
    );

    gpio_bus_fsm #(.PINS(PINS), .ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .lvl        (lvl),
        .dir        (dir),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .stat       (stat),
        .wr_bank    (wr_bank),
        .wr_type    (wr_type),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        gpio_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_bank[b]),
            .wr_type   (wr_type),
            .wdata     (bus_wdata),
            .rise_p    (rise_p[b*BANK_W +: BANK_W]),
            .fall_p    (fall_p[b*BANK_W +: BANK_W]),
            .dir_q     (dir[b*BANK_W +: BANK_W]),
            .out_q     (outl[b*BANK_W +: BANK_W]),
            .rise_en_q (rise_en[b*BANK_W +: BANK_W]),
            .fall_en_q (fall_en[b*BANK_W +: BANK_W]),
            .stat_q    (stat[b*BANK_W +: BANK_W])
        );
    end

    assign pin_out = outl;
    assign pin_oe  = dir;
    assign irq     = |stat;

    AST_IRQ_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_en && bus_we)); // R9
endmodule

// File: tb/tb_gpio_banked_ctrl.sv
module tb_gpio_banked_ctrl;
    localparam int PINS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_banked_ctrl #(.PINS(PINS), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // byte addresses for PINS=64 (two banks): type*8 + bank*4
    function automatic logic [7:0] ra(int t, int b);
        return 8'(t * 8 + b * 4);
    endfunction

    task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when read data is presented
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check_val(it.tag, 64'(bus_rdata), 64'(it.exp));
            end
        end
    end

    task automatic wr_now(logic [7:0] a, logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic rd_now(logic [7:0] a, logic [31:0] e, string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        rd_now(a, e, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check_val("R11 pin_oe", pin_oe, '0);
        check_val("R11 pin_out", pin_out, '0);
        check_val("R11 irq", 64'(irq), 64'd0);
        rd(ra(1, 0), 32'h0, "R11 dir reset");
        rd(ra(6, 1), 32'h0, "R11 stat reset");
        rd(ra(4, 0), 32'h0, "R11 rise en reset");

        // R1 / R2 direction
        wr(ra(1, 0), 32'hA5A5_0F0F);
        check_val("R2 pin_oe bank0", 64'(pin_oe[31:0]), 64'hA5A5_0F0F);
        wr(ra(1, 1), 32'h0000_0001);
        check_val("R2 pin_oe bank1", pin_oe, 64'h0000_0001_A5A5_0F0F);
        rd(ra(1, 0), 32'hA5A5_0F0F, "R1 dir bank0");
        rd(ra(1, 1), 32'h0000_0001, "R1 dir bank1");

        // R3 set, R4 clear
        wr(ra(2, 0), 32'h0000_00FF);
        check_val("R3 set", pin_out, 64'h0000_00FF);
        wr(ra(2, 0), 32'h0000_0100);
        check_val("R3 zeros keep", pin_out, 64'h0000_01FF);
        wr(ra(3, 0), 32'h0000_000F);
        check_val("R4 clear", pin_out, 64'h0000_01F0);
        wr(ra(2, 1), 32'h8000_0000);
        check_val("R3 set bank1", pin_out, 64'h8000_0000_0000_01F0);
        wr(ra(3, 1), 32'h0);
        check_val("R4 zeros keep", pin_out, 64'h8000_0000_0000_01F0);
        rd(ra(2, 0), 32'h0, "R10 set reads zero");
        rd(ra(3, 1), 32'h0, "R10 clear reads zero");

        // R5 level with synchroniser latency
        @(negedge clk);
        pin_in = 64'h1234_5678_9ABC_DEF0;
        rd_now(ra(0, 0), 32'h0, "R5 level not yet synced");
        repeat (2) @(negedge clk);
        rd(ra(0, 0), 32'h9ABC_DEF0, "R5 level bank0");
        rd(ra(0, 1), 32'h1234_5678, "R5 level bank1");
        @(negedge clk);
        pin_in = '0;
        repeat (3) @(negedge clk);

        // R6 edge capture; bit0 rising, bit1 falling, bit32 both
        wr(ra(4, 0), 32'h1);
        wr(ra(5, 0), 32'h2);
        wr(ra(4, 1), 32'h1);
        wr(ra(5, 1), 32'h1);
        rd(ra(5, 0), 32'h2, "R1 fall en readback");
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        check_val("R9 irq not before capture", 64'(irq), 64'd0);
        @(negedge clk);
        check_val("R9 irq after rising capture", 64'(irq), 64'd1);
        rd(ra(6, 0), 32'h1, "R6 rising captured");
        @(negedge clk); pin_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(6, 0), 32'h1, "R6 rise on fall-only pin ignored");
        @(negedge clk); pin_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        rd(ra(6, 0), 32'h3, "R6 falling captured");
        @(negedge clk); pin_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(6, 0), 32'h3, "R6 disabled pin ignored");

        // R7 sticky, write-one-to-clear
        wr(ra(6, 0), 32'h0);
        rd(ra(6, 0), 32'h3, "R7 write zero no effect");
        wr(ra(6, 0), 32'h1);
        rd(ra(6, 0), 32'h2, "R7 write one clears");
        check_val("R9 irq with one bit", 64'(irq), 64'd1);

        // R8 edge and acknowledge collide on bit1
        @(negedge clk); pin_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk); pin_in[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_now(ra(6, 0), 32'h2);
        rd(ra(6, 0), 32'h2, "R8 edge wins over clear");
        wr(ra(6, 0), 32'h2);
        rd(ra(6, 0), 32'h0, "R7 cleared");
        check_val("R9 irq low when clear", 64'(irq), 64'd0);

        // bank1 pin32 both edges
        @(negedge clk); pin_in[32] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(6, 1), 32'h1, "R6 bank1 rising");
        check_val("R9 irq from bank1", 64'(irq), 64'd1);
        wr(ra(6, 1), 32'h1);
        @(negedge clk); pin_in[32] = 1'b0;
        repeat (3) @(negedge clk);
        rd(ra(6, 1), 32'h1, "R6 bank1 falling");
        wr(ra(6, 1), 32'h1);
        @(negedge clk);
        check_val("R9 irq low again", 64'(irq), 64'd0);

        // R10 out of range and unaligned
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, 32'h0, "R10 past last type reads zero");
        wr(8'h09, 32'h0);
        rd(ra(1, 0), 32'hA5A5_0F0F, "R10 ignored writes");
        rd(8'h0A, 32'h0, "R10 unaligned reads zero");
        check_val("R10 pin_oe unchanged", pin_oe, 64'h0000_0001_A5A5_0F0F);

        repeat (3) @(negedge clk);
        check_val("R5 scoreboard drained", 64'(sb_q.size()), 64'd0);
        finish_run();
    end
endmodule